// File: doc/BRIEF.md
# Range-Selectable Sliding-Window Mean Filter

This block smooths a stream of signed rate samples. It takes the mean over a sliding window of N = 2^M samples. It then scales the mean to suit one of three measurement ranges. For each accepted sample it produces one filtered value and one valid strobe, once the window is full.

A 16-bit configuration word is written through a simple write-enable port and can always be read back. The word holds two fields:
- a range code in bits 10:8;
- a window exponent M in bits 3:0.

The block rewrites every value it stores into a legal form:
- an unknown range code becomes the widest range;
- M is capped at its maximum;
- for the two narrower ranges, M is raised to a floor so that resolution is kept.

Any change to the stored word empties the window, and filtering restarts from nothing.

Top module: `range_avg_filter`

## Requirements
- R1: After reset the configuration reads 0x0402 (range code 100, M = 2) and out_valid is low.
- R2: Readback holds the range code in bits 10:8 and M in bits 3:0. Bits 15:11 and 7:4 always read zero.
- R3: The stored range code is 001 or 010 when that code is written. Any other written code is stored as 100.
- R4: A written M greater than 10 is stored as 10.
- R5: With range 010 the stored M is at least 2. With range 001 it is at least 4. A smaller written M is raised to that floor.
- R6: out_valid rises one cycle after an accepted sample, and only when at least 2^M samples have been accepted since the last flush. After that, each accepted sample gives exactly one strobe.
- R7: out_data is the sum of the last 2^M samples shifted arithmetically right by M. That result is then shifted left by 0, 1 or 2 for range 100, 010 or 001.
- R8: A write that changes the stored word empties the window. A write that leaves the stored word unchanged does not disturb the window.
- R9: A sample presented in the same cycle as a write that changes the stored word is discarded.
- R10: A cycle with in_valid low produces no strobe and leaves the window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Stored configuration readback |
| in_valid | input | 1 | Input sample valid |
| in_data | input | W (16) | Signed input sample |
| out_valid | output | 1 | Filtered output strobe |
| out_data | output | W+2 (18) | Signed scaled mean |

## Verification
Some properties are checked by the assertions on every cycle:
- the zero bits of the readback;
- the legality of the stored range and exponent, including the floors and the cap;
- that each strobe follows an accepted sample;
- that the output is silent in the cycle in which the configuration changes;
- the zero low bits of the scaled output for the narrower ranges.

Other behaviour needs a reference model of the window, so only the bench scenarios can show it:
- the mean itself, including rounding toward minus infinity for negative sums;
- the exact moment the window fills;
- that a write which changes nothing leaves filtering undisturbed;
- that a sample colliding with a changing write is dropped.

// File: rtl/range_avg_filter.sv
module range_avg_filter #(
  parameter int W    = 16,
  parameter int MMAX = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [15:0]         cfg_wdata,
  output logic [15:0]         cfg_rdata,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W+1:0] out_data
);
  localparam int DEPTH = 1 << MMAX;
  localparam int AW    = (MMAX < 1) ? 1 : MMAX;
  localparam int CW    = MMAX + 1;
  localparam int SW    = W + MMAX + 1;
  localparam int OW    = W + 2;
  localparam logic [3:0] M_CAP = 4'(MMAX);

  logic [2:0] rng_q;
  logic [3:0] m_q;

  function automatic logic [6:0] legalize(input logic [15:0] d);
    logic [2:0] r;
    logic [3:0] m;
    r = (d[10:8] == 3'b001 || d[10:8] == 3'b010) ? d[10:8] : 3'b100;
    m = (d[3:0] > M_CAP) ? M_CAP : d[3:0];
    if (r == 3'b001 && m < 4'd4) m = 4'd4;
    if (r == 3'b010 && m < 4'd2) m = 4'd2;
    return {r, m};
  endfunction

  logic [6:0] cfg_new;
  logic       flush;
  assign cfg_new   = legalize(cfg_wdata);
  assign flush     = cfg_we && (cfg_new != {rng_q, m_q});
  assign cfg_rdata = {5'd0, rng_q, 4'd0, m_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng_q <= 3'b100;
      m_q   <= 4'd2;
    end else if (flush) begin
      rng_q <= cfg_new[6:4];
      m_q   <= cfg_new[3:0];
    end
  end

  logic signed [W-1:0]  mem [DEPTH];
  logic [AW-1:0]        ptr_q;
  logic [CW-1:0]        cnt_q;
  logic signed [SW-1:0] sum_q;

  logic [CW-1:0]        n_taps;
  logic                 full;
  logic                 take;
  logic signed [W-1:0]  oldest;
  logic signed [SW-1:0] sum_nxt;
  logic [CW-1:0]        cnt_nxt;
  logic [AW-1:0]        ptr_mask;
  logic signed [SW-1:0] mean_wide;
  logic signed [W-1:0]  mean;
  logic signed [OW-1:0] scaled;

  assign n_taps    = CW'(1) << m_q;
  assign full      = (cnt_q == n_taps);
  assign take      = in_valid && !flush;
  assign oldest    = full ? mem[ptr_q] : '0;
  assign sum_nxt   = sum_q + SW'(in_data) - SW'(oldest);
  assign cnt_nxt   = full ? cnt_q : cnt_q + CW'(1);
  assign ptr_mask  = AW'(n_taps - CW'(1));
  assign mean_wide = sum_nxt >>> m_q;
  assign mean      = mean_wide[W-1:0];

  always_comb begin
    unique case (rng_q)
      3'b010:  scaled = OW'(mean) <<< 1;
      3'b001:  scaled = OW'(mean) <<< 2;
      default: scaled = OW'(mean);
    endcase
  end

  always_ff @(posedge clk) begin
    if (take) mem[ptr_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr_q     <= '0;
      cnt_q     <= '0;
      sum_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      ptr_q     <= (ptr_q + AW'(1)) & ptr_mask;
      cnt_q     <= cnt_nxt;
      sum_q     <= sum_nxt;
      out_valid <= (cnt_nxt == n_taps);
      out_data  <= scaled;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/range_avg_filter_chk.sv
module range_avg_filter_chk #(
  parameter int W    = 16,
  parameter int MMAX = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                out_valid,
  input logic signed [W+1:0] out_data,
  input logic [15:0]         cfg_rdata
);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:11] == 5'd0 && cfg_rdata[7:4] == 4'd0);

  a_r3_legal_range: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_rdata[10:8]) == 1);

  a_r4_m_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:0] <= 4'(MMAX));

  a_r5_floor_80: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[10:8] == 3'b001 |-> cfg_rdata[3:0] >= 4'd4);

  a_r5_floor_160: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[10:8] == 3'b010 |-> cfg_rdata[3:0] >= 4'd2);

  a_r6_strobe_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r8_silent_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_rdata) |-> !out_valid);

  a_r7_scale_160: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_rdata[10:8] == 3'b010) |-> out_data[0] == 1'b0);

  a_r7_scale_80: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_rdata[10:8] == 3'b001) |-> out_data[1:0] == 2'b00);
endmodule

bind range_avg_filter range_avg_filter_chk #(.W(W), .MMAX(MMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .cfg_rdata(cfg_rdata)
);

// File: tb/range_avg_filter_tb.sv
module range_avg_filter_tb;
  localparam int W = 16;
  localparam int MMAX = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic out_valid;
  logic signed [W+1:0] out_data;

  always #10 clk = ~clk;

  range_avg_filter #(.W(W), .MMAX(MMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int q[$];
  logic [15:0] cfg_exp = 16'h0402;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] legal_cfg(input logic [15:0] d);
    logic [2:0] r;
    int m;
    r = (d[10:8] == 3'b001 || d[10:8] == 3'b010) ? d[10:8] : 3'b100;
    m = (d[3:0] > MMAX) ? MMAX : int'(d[3:0]);
    if (r == 3'b001 && m < 4) m = 4;
    if (r == 3'b010 && m < 2) m = 2;
    return {5'd0, r, 4'd0, 4'(m)};
  endfunction

  function automatic longint exp_out();
    longint s = 0;
    int m = int'(cfg_exp[3:0]);
    int sh = (cfg_exp[10:8] == 3'b010) ? 1 : (cfg_exp[10:8] == 3'b001) ? 2 : 0;
    foreach (q[i]) s += q[i];
    s = s >>> m;
    return s * (longint'(1) << sh);
  endfunction

  task automatic model_take(input int v);
    int n = 1 << cfg_exp[3:0];
    q.push_back(v);
    if (q.size() > n) void'(q.pop_front());
  endtask

  task automatic check_out(input string tag);
    bit ev = (q.size() == (1 << cfg_exp[3:0]));
    chk(out_valid == ev, {tag, " R6 valid"}, out_valid, ev);
    if (ev && out_valid)
      chk(longint'(out_data) == exp_out(), {tag, " R7 data"}, out_data, exp_out());
  endtask

  task automatic send(input int v, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = W'(v);
    @(posedge clk);
    model_take(v);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 idle no strobe", out_valid, 0);
  endtask

  task automatic wr(input logic [15:0] d, input bit with_s, input int v, input string tag);
    logic [15:0] nc = legal_cfg(d);
    bit changed = (nc != cfg_exp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    in_valid = with_s; in_data = W'(v);
    @(posedge clk);
    if (changed) begin
      cfg_exp = nc;
      q.delete();
    end else if (with_s) model_take(v);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk(cfg_rdata == cfg_exp, {tag, " R2 R3 R4 R5 readback"}, cfg_rdata, cfg_exp);
    if (changed) chk(out_valid == 1'b0, {tag, " R8 R9 flush"}, out_valid, 0);
    else if (with_s) check_out({tag, " R8 nochange"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog timeout", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cfg_rdata == 16'h0402, "R1 reset cfg", cfg_rdata, 16'h0402);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    rst_n = 1'b1;

    // R6: default M=2, strobe only from 4th sample
    send(100, "R6 d1"); send(200, "R6 d2"); send(300, "R6 d3"); send(400, "R6 d4");
    send(-500, "R7 d5");
    idle();
    send(7, "R10 window kept");

    // R3 R4: illegal code and huge M
    wr(16'hFFFF, 0, 0, "R3 R4 ffff");
    chk(cfg_rdata == 16'h040A, "R4 cap value", cfg_rdata, 16'h040A);
    // R5 floors
    wr(16'h0100, 0, 0, "R5 80 floor");
    chk(cfg_rdata[3:0] == 4'd4, "R5 m4", cfg_rdata[3:0], 4);
    wr(16'h0201, 0, 0, "R5 160 floor");
    chk(cfg_rdata[3:0] == 4'd2, "R5 m2", cfg_rdata[3:0], 2);

    // R7 negative rounding: -1,0,0,0 with M=2 range 100 -> -1
    wr(16'h0402, 0, 0, "R7 cfg");
    send(-1, "R7 r1"); send(0, "R7 r2"); send(0, "R7 r3"); send(0, "R7 r4");
    chk(out_data == -18'sd1, "R7 floor negative", out_data, -1);

    // R8: same-value write keeps window, sample accepted with it
    wr(16'hF4F2, 1, 55, "R8 same value");
    send(9, "R8 after");

    // R9: changing write with sample drops the sample
    wr(16'h0000, 1, 999, "R9 collide");
    send(-32768, "R9 first after flush");

    // R7 extremes on range 001
    wr(16'h0104, 0, 0, "R7 80 cfg");
    for (int i = 0; i < 16; i++) send(-32768, "R7 min 80");
    chk(out_data == -18'sd131072, "R7 min scaled", out_data, -131072);
    for (int i = 0; i < 16; i++) send(32767, "R7 max 80");

    // random phases
    for (int p = 0; p < 14; p++) begin
      logic [15:0] d = 16'($urandom);
      int n;
      wr(d, 0, 0, "rand cfg");
      n = (1 << cfg_exp[3:0]) + int'($urandom_range(0, 40));
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 7) == 0) idle();
        send(int'($signed(W'($urandom))), "rand");
      end
    end
    finish_run();
  end
endmodule